// File: doc/BRIEF.md
# Port Edge Counter and Capture Detector

This block watches the input pins of an 8-bit port. The top pin feeds an event counter whose active edge can be selected. The three lowest pins feed three capture detectors, and each detector has its own 2-bit edge mode. Every pin first passes through a two-flop synchronizer. A per-bit acceptance mask then merges the synchronized pins into a held port image. The mask depends on whether the top pin is configured as an input or as an output. Edges are found by comparing the new image with the held one.

When a detector fires, it sets a sticky flag and sends a one-cycle strobe that carries its unit number. Unit numbers run in reverse order to bit positions: bit 0 is unit 3, bit 1 is unit 2 and bit 2 is unit 1. A counter wrap sets a sticky overflow flag. A one-cycle interrupt-update pulse marks every cycle in which any flag goes from 0 to 1. Software clears flags by writing ones to their bit positions.

The block does not latch a timer value and does not vector interrupts. Nothing streams through it: every pin is plain control or status, and there is no back-pressure. The strobe is a single-cycle pulse that the consumer must take in the cycle it appears.

Top module: `pacap_top`

## Requirements
- R1: When `hi_dir_out`=0, only pins 0, 1 and 7 update the held port image. Every other bit keeps its previous value, so a change on pin 2 (or on pins 3 to 6) never produces a capture, even with capture mode 11 on channel 2.
- R2: When `hi_dir_out`=1, only pins 0 and 1 update the image. Bit 7 holds its old value, and changes on pin 7 are not counted.
- R3: A pin change that is held steady appears at `pulse_cnt`, the flags, `cap_stb` and `irq_update` on the third rising clock edge after it is applied, and not before.
- R4: The counter advances on a bit-7 change only when `acc_en`=1 and `acc_gated`=0.
- R5: With `acc_rise`=1, a 0-to-1 change on bit 7 counts. With `acc_rise`=0, a 1-to-0 change counts. The other direction never counts.
- R6: `pulse_cnt` is 8 bits wide and wraps from 255 to 0. A counted event that leaves it at 0 sets `ovf_flag`.
- R7: Channel i (i = 0, 1, 2) takes its mode from `cap_mode[2i+1:2i]`: 00 is off, 01 captures on rising edges, 10 on falling edges, 11 on both.
- R8: A capture on channel i sets `cap_flags[i]`. In the same cycle `cap_stb` is high for one cycle and `cap_unit` = 3−i. When several channels capture in the same cycle, all their flags are set and `cap_unit` reports the lowest unit number.
- R9: Flags are sticky. When `clr_we`=1, each 1 in `clr_bits` clears one flag: bit 3 clears `ovf_flag` and bits 2:0 clear `cap_flags[2:0]`. If a flag is set and cleared in the same cycle, the set wins.
- R10: `irq_update` is high for exactly those cycles in which at least one flag goes from 0 to 1. A capture on a flag that is already set produces a strobe but no `irq_update`.
- R11: Reset clears the synchronizer, the held image, the count, all flags, `cap_stb` and `irq_update`. A pin that is high when reset ends is therefore seen as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Raw, unsynchronized port pins |
| hi_dir_out | input | 1 | 1: bit 7 is an output, so its pin is ignored |
| acc_en | input | 1 | Counter enable |
| acc_gated | input | 1 | 1: gated mode, so no event counting |
| acc_rise | input | 1 | 1: count rising edges on bit 7; 0: count falling edges |
| cap_mode | input | 6 | 2-bit edge mode for each capture channel |
| clr_we | input | 1 | Flag-clear write strobe |
| clr_bits | input | 4 | Write-one-to-clear mask: [3] overflow, [2:0] capture flags |
| pulse_cnt | output | 8 | Event count |
| ovf_flag | output | 1 | Sticky counter-wrap flag |
| cap_flags | output | 3 | Sticky capture flags, bit i for channel i |
| cap_stb | output | 1 | One-cycle capture strobe |
| cap_unit | output | 2 | Unit number of the reported capture (3−i) |
| irq_update | output | 1 | One-cycle pulse when any flag rises |

## Verification
A corrupted held port image shows up on the next pin change as a count or capture that is missing or should not be there, three edges after the stimulus. A wrong count shows on `pulse_cnt` at once and reaches `ovf_flag` only at the wrap. A broken flag register shows on `cap_flags` or `ovf_flag` in the same cycle, but its effect on `irq_update` appears only when that flag is next due to rise. The scoreboard pairs every strobe with its predicted unit number, so a reversed mapping or the wrong choice between simultaneous captures is reported in the cycle the strobe appears.

// File: rtl/pacap_pkg.sv
`timescale 1ns/1ps
package pacap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  // Decide whether a changed bit at its new level qualifies under a mode.
  function automatic logic edge_hit(edge_mode_e m, logic chg, logic lvl);
    case (m)
      EDGE_RISE: return chg & lvl;
      EDGE_FALL: return chg & ~lvl;
      EDGE_ANY:  return chg;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pacap_insync.sv
`timescale 1ns/1ps
module pacap_insync #(
  parameter int            W           = 8,
  parameter logic [W-1:0]  MASK_HI_IN  = 8'h83,
  parameter logic [W-1:0]  MASK_HI_OUT = 8'h03
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic         hi_dir_out,
  output logic [W-1:0] cur_v,
  output logic [W-1:0] delta
);
  logic [W-1:0] s1_q, s2_q, prev_q, accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      prev_q <= cur_v;
    end
  end

  always_comb begin
    accept = hi_dir_out ? MASK_HI_OUT : MASK_HI_IN;
    cur_v  = (s2_q & accept) | (prev_q & ~accept);
    delta  = cur_v ^ prev_q;
  end

  // R1: bits outside the widest acceptance mask never move
  a_r1_hold_outside: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(prev_q & ~MASK_HI_IN));
  // R2: with the top bit as an output, its image bit is frozen
  a_r2_hi_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hi_dir_out) |-> prev_q[W-1] == $past(prev_q[W-1]));
endmodule

// File: rtl/pacap_accum.sv
`timescale 1ns/1ps
module pacap_accum #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             gated,
  input  logic             rise,
  input  logic             chg,
  input  logic             lvl,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  logic inc;

  always_comb begin
    inc  = en && !gated && chg && (rise ? lvl : !lvl);
    wrap = inc && (cnt == TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  // R4: counter frozen while disabled or gated
  a_r4_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en || gated) |-> cnt == $past(cnt));
  // R6: a wrap always lands on zero
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);
  // R5: the counter moves by at most one per cycle
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/pacap_capture.sv
`timescale 1ns/1ps
module pacap_capture
  import pacap_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       chg,
  input  logic       lvl,
  output logic       hit
);
  always_comb hit = edge_hit(edge_mode_e'(mode), chg, lvl);
endmodule

// File: rtl/pacap_top.sv
`timescale 1ns/1ps
module pacap_top #(
  parameter int                 PORT_W      = 8,
  parameter int                 CNT_W       = 8,
  parameter int                 N_CAP       = 3,
  parameter int                 UNIT_W      = $clog2(N_CAP + 1),
  parameter logic [PORT_W-1:0]  MASK_HI_IN  = 8'h83,
  parameter logic [PORT_W-1:0]  MASK_HI_OUT = 8'h03
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PORT_W-1:0]  pin_in,
  input  logic               hi_dir_out,
  input  logic               acc_en,
  input  logic               acc_gated,
  input  logic               acc_rise,
  input  logic [2*N_CAP-1:0] cap_mode,
  input  logic               clr_we,
  input  logic [N_CAP:0]     clr_bits,
  output logic [CNT_W-1:0]   pulse_cnt,
  output logic               ovf_flag,
  output logic [N_CAP-1:0]   cap_flags,
  output logic               cap_stb,
  output logic [UNIT_W-1:0]  cap_unit,
  output logic               irq_update
);
  localparam int ACC_BIT = PORT_W - 1;

  logic [PORT_W-1:0] cur_v, delta;
  logic [N_CAP-1:0]  hits, cap_nxt;
  logic              wrap, ovf_nxt, irq_nxt;
  logic [N_CAP:0]    clr_eff, flags_all;
  logic [UNIT_W-1:0] unit_nxt;

  pacap_insync #(.W(PORT_W), .MASK_HI_IN(MASK_HI_IN), .MASK_HI_OUT(MASK_HI_OUT)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .hi_dir_out(hi_dir_out),
    .cur_v(cur_v), .delta(delta));

  pacap_accum #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(acc_en), .gated(acc_gated), .rise(acc_rise),
    .chg(delta[ACC_BIT]), .lvl(cur_v[ACC_BIT]), .cnt(pulse_cnt), .wrap(wrap));

  for (genvar g = 0; g < N_CAP; g++) begin : g_cap
    pacap_capture u_cap (
      .mode(cap_mode[2*g +: 2]), .chg(delta[g]), .lvl(cur_v[g]), .hit(hits[g]));
  end

  always_comb begin
    clr_eff  = clr_we ? clr_bits : '0;
    ovf_nxt  = (ovf_flag & ~clr_eff[N_CAP]) | wrap;
    cap_nxt  = (cap_flags & ~clr_eff[N_CAP-1:0]) | hits;
    irq_nxt  = |({wrap, hits} & ~{ovf_flag, cap_flags});
    unit_nxt = '0;
    for (int i = 0; i < N_CAP; i++)
      if (hits[i]) unit_nxt = UNIT_W'(N_CAP - i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag   <= 1'b0;
      cap_flags  <= '0;
      cap_stb    <= 1'b0;
      cap_unit   <= '0;
      irq_update <= 1'b0;
    end else begin
      ovf_flag   <= ovf_nxt;
      cap_flags  <= cap_nxt;
      cap_stb    <= |hits;
      cap_unit   <= unit_nxt;
      irq_update <= irq_nxt;
    end
  end

  assign flags_all = {ovf_flag, cap_flags};

  // R9: a flag never drops without a clear request
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flags_all) & ~$past(clr_eff) & ~flags_all) == '0);
  // R10: an update pulse always comes with a newly risen flag
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_update |-> (flags_all & ~$past(flags_all)) != '0);
  // R8: the reported unit is in range and its flag is set
  a_r8_unit_range: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> (cap_unit >= UNIT_W'(1)) && (int'(cap_unit) <= N_CAP));
  a_r8_unit_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> ((cap_flags >> (N_CAP - int'(cap_unit))) & 1) != 0);
  // R1: no change is ever seen outside the widest mask
  a_r1_quiet_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ((delta | cur_v) & ~MASK_HI_IN) == '0);
endmodule

// File: tb/sim_pacap_top.sv
`timescale 1ns/1ps
module sim_pacap_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = 8'h01;
  logic       hi_dir_out = 1'b0, acc_en = 1'b0, acc_gated = 1'b0, acc_rise = 1'b0;
  logic [5:0] cap_mode = 6'b000001;
  logic       clr_we = 1'b0;
  logic [3:0] clr_bits = 4'h0;
  logic [7:0] pulse_cnt;
  logic       ovf_flag, cap_stb, irq_update;
  logic [2:0] cap_flags;
  logic [1:0] cap_unit;

  always #2.5 clk = ~clk;

  pacap_top u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .hi_dir_out(hi_dir_out),
    .acc_en(acc_en), .acc_gated(acc_gated), .acc_rise(acc_rise),
    .cap_mode(cap_mode), .clr_we(clr_we), .clr_bits(clr_bits),
    .pulse_cnt(pulse_cnt), .ovf_flag(ovf_flag), .cap_flags(cap_flags),
    .cap_stb(cap_stb), .cap_unit(cap_unit), .irq_update(irq_update));

  int total = 0, bad = 0, irq_seen = 0, irq_exp = 0;
  bit finished = 0;
  int exp_q[$];
  logic [7:0] mp = 8'h00, mcnt = 8'h00;
  logic       movf = 1'b0;
  logic [2:0] mcap = 3'b000;

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  // Monitor: pop the predicted unit for every strobe, and count update pulses.
  always @(negedge clk) begin
    if (rst_n && cap_stb) begin
      if (exp_q.size() == 0) chk("R8 unexpected strobe unit", int'(cap_unit), 0);
      else chk("R8 strobe unit", int'(cap_unit), exp_q.pop_front());
    end
    if (rst_n && irq_update) irq_seen++;
  end

  task automatic model_step(input logic [7:0] v);
    logic [7:0] m, nv, d;
    logic inc, rose;
    logic [2:0] hit;
    int unit;
    m = hi_dir_out ? 8'h03 : 8'h83;
    nv = (v & m) | (mp & ~m);
    d = nv ^ mp;
    mp = nv;
    rose = 1'b0;
    inc = acc_en && !acc_gated && d[7] && (acc_rise ? nv[7] : !nv[7]);
    if (inc) begin
      mcnt = mcnt + 8'd1;
      if (mcnt == 8'd0) begin
        if (!movf) rose = 1'b1;
        movf = 1'b1;
      end
    end
    hit = 3'b000;
    unit = 0;
    for (int i = 0; i < 3; i++)
      if (d[i])
        case (cap_mode[2*i +: 2])
          2'b01:   hit[i] = nv[i];
          2'b10:   hit[i] = !nv[i];
          2'b11:   hit[i] = 1'b1;
          default: hit[i] = 1'b0;
        endcase
    for (int i = 0; i < 3; i++)
      if (hit[i]) begin
        if (!mcap[i]) rose = 1'b1;
        mcap[i] = 1'b1;
        unit = 3 - i;
      end
    if (hit != 3'b000) exp_q.push_back(unit);
    if (rose) irq_exp++;
  endtask

  task automatic check_state(string tag);
    chk({tag, " count(R4/R5/R6)"}, int'(pulse_cnt), int'(mcnt));
    chk({tag, " overflow(R6)"}, int'(ovf_flag), int'(movf));
    chk({tag, " cap flags(R7)"}, int'(cap_flags), int'(mcap));
    chk({tag, " update pulses(R10)"}, irq_seen, irq_exp);
    chk({tag, " missing strobe(R8)"}, exp_q.size(), 0);
  endtask

  // Driver: predict, apply at a falling edge, wait past the sync latency.
  task automatic apply(input logic [7:0] v, input string tag);
    model_step(v);
    pin_in = v;
    repeat (4) @(negedge clk);
    check_state(tag);
  endtask

  task automatic clear(input logic [3:0] b, input string tag);
    clr_we = 1'b1;
    clr_bits = b;
    @(negedge clk);
    clr_we = 1'b0;
    clr_bits = 4'h0;
    if (b[3]) movf = 1'b0;
    mcap = mcap & ~b[2:0];
    @(negedge clk);
    check_state(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset count", int'(pulse_cnt), 0);
    chk("R11 reset flags", int'({ovf_flag, cap_flags}), 0);
    chk("R11 reset strobe/irq", int'({cap_stb, irq_update}), 0);
    rst_n = 1'b1;
    apply(8'h01, "R11 high pin after reset captures");
    clear(4'b0001, "R9 clear cap0");

    // R3 latency on channel 1, falling mode
    cap_mode = 6'b001000;
    apply(8'h03, "R7 rising ignored in fall mode");
    model_step(8'h01);
    pin_in = 8'h01;
    repeat (2) @(negedge clk);
    chk("R3 not yet after two edges", int'(cap_flags[1]), 0);
    @(negedge clk);
    chk("R3 set after third edge", int'(cap_flags[1]), 1);
    @(negedge clk);
    check_state("R3 latency");

    // R7 both-edge mode, R10 no pulse when already set
    cap_mode = 6'b001011;
    apply(8'h00, "R7 any-edge fall");
    apply(8'h01, "R10 rehit no update");

    // R8 simultaneous capture
    clear(4'b1111, "R9 clear all");
    cap_mode = 6'b000101;
    apply(8'h00, "R7 falling ignored in rise mode");
    apply(8'h03, "R8 simultaneous lowest unit");

    // R1 pin 2 and pins 3..6 ignored
    cap_mode = 6'b110101;
    apply(8'h07, "R1 pin2 rise ignored");
    apply(8'h7B, "R1 upper pins ignored");
    apply(8'h03, "R1 pin2 fall ignored");

    // R9 set wins over same-cycle clear (cap0 already set)
    cap_mode = 6'b000011;
    model_step(8'h02);
    pin_in = 8'h02;
    repeat (2) @(negedge clk);
    clr_we = 1'b1;
    clr_bits = 4'b0001;
    @(negedge clk);
    clr_we = 1'b0;
    clr_bits = 4'h0;
    @(negedge clk);
    check_state("R9 set beats clear");

    // R4 enable and gating
    apply(8'h82, "R4 disabled");
    apply(8'h02, "R4 disabled");
    acc_en = 1'b1;
    acc_gated = 1'b1;
    apply(8'h82, "R4 gated");
    apply(8'h02, "R4 gated");
    acc_gated = 1'b0;
    // R5 edge select
    apply(8'h82, "R5 rise not counted in fall mode");
    apply(8'h02, "R5 fall counted");
    acc_rise = 1'b1;
    apply(8'h82, "R5 rise counted");
    apply(8'h02, "R5 fall not counted in rise mode");
    // R2 top bit as output
    hi_dir_out = 1'b1;
    apply(8'h82, "R2 output bit ignored");
    apply(8'h02, "R2 output bit ignored");
    hi_dir_out = 1'b0;
    repeat (4) @(negedge clk);
    check_state("R2 back to input");

    // R6 wrap and overflow
    do begin
      apply(8'h82, "R6 climb");
      apply(8'h02, "R6 climb");
    end while (mcnt != 8'd0);
    chk("R6 wrapped to zero", int'(pulse_cnt), 0);
    chk("R6 overflow set", int'(ovf_flag), 1);
    clear(4'b1000, "R9 clear overflow");
    apply(8'h82, "R6 count after wrap");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule